// File: doc/BRIEF.md
# Configuration Image Header Parser

This block sits between a byte-wide store of a configuration image and the sequencer that shifts that image into a programmable device. It reads the image one byte at a time. It recognises the container format and forwards only the raw bitstream bytes, together with their length.

The container starts with a fixed 13-byte preamble. After the preamble come tagged sections. Each section has a one-byte letter tag, a big-endian length and then that many content bytes. The bitstream section, tag `e`, carries a 32-bit length. Tags `a` to `d` carry a 16-bit length and are discarded.

An image that starts with the legacy raw-image marker is handled differently. It is forwarded as a fixed number of 32-bit words, marker included, with the bytes of every word reversed. A flag tells the sequencer which mode is in use. The parser reports success, absence or a malformed header with single-cycle status pulses. It then discards the rest of the image up to the end-of-image flag and is ready for the next image.

Top module: `cfg_image_parser`

## Requirements
- R1: An image whose first byte is not `FF` must start with exactly `00 09 0F F0 0F F0 0F F0 0F F0 00 00 01`. A wrong byte in these 13 positions pulses `miss` in the cycle that byte is accepted.
- R2: After the preamble, sections tagged `a` (0x61) to `d` (0x64) take a two-byte big-endian length. Exactly that many content bytes are accepted and dropped, and none of them appears on the output.
- R3: Section `e` (0x65) takes a four-byte big-endian length. Its content bytes leave on `out_data` unchanged and in order. `pay_len` shows the length from the cycle after the last length byte, and `byte_rev` is 0.
- R4: A section tag outside 0x61..0x65 pulses `err`.
- R5: A tag other than `e` whose length exceeds 255 pulses `err`. A length of exactly 255 is accepted and skipped.
- R6: Reaching the end-of-image byte (`in_last`) before any `e` payload starts pulses `miss`.
- R7: `found` pulses exactly once per image. For a non-empty payload it pulses in the cycle the last payload byte is transferred. For an `e` section of length 0 it pulses on the last length byte.
- R8: While `out_ready` is low during payload output, `out_valid` data is neither lost nor duplicated and no input byte is taken past it.
- R9: An image whose stream starts `FF FF FF FF 66 55 99 AA` sets `byte_rev` to 1 and `pay_len` to 42096. It forwards 42096 bytes starting from the first image byte, and each group of four input bytes leaves in reverse order. The first eight output bytes are therefore `FF FF FF FF AA 99 55 66`.
- R10: An image that starts with `FF` but differs from the legacy marker in its first eight bytes pulses `miss`.
- R11: After any status pulse, bytes are discarded up to and including the next `in_last`. Parsing then restarts at the first preamble byte. At most one of `found`, `miss`, `err` is high in any cycle.
- R12: `in_last` arriving before an announced payload is complete pulses `err`, after forwarding the bytes that did arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Image byte available |
| in_data | input | 8 | Image byte |
| in_last | input | 1 | Marks the final byte of the image |
| in_ready | output | 1 | Parser takes the byte this cycle |
| out_valid | output | 1 | Payload byte available |
| out_data | output | 8 | Payload byte |
| out_ready | input | 1 | Sequencer takes the payload byte |
| pay_len | output | 32 | Payload length in bytes of the current image |
| byte_rev | output | 1 | 1 when the legacy raw image is being forwarded |
| found | output | 1 | Pulse: payload completely forwarded |
| miss | output | 1 | Pulse: no recognisable payload in the image |
| err | output | 1 | Pulse: malformed or truncated header or payload |

## Verification
A section counter that drifts by even one byte makes the parser read a content byte as the next tag. Within a few bytes this shows at the ports as a spurious `err` or `miss`, or as payload bytes that are missing, extra or shifted, and the byte-by-byte scoreboard catches it. A slip in the reversal buffer shows up within the first output group as a wrong byte order. A wrong legacy byte count shows at the end of the 42096-byte run as a missing `found` or as leftover expected bytes. Stalled output is exercised with random back-pressure, so any byte lost or repeated at a stall shows up as a scoreboard mismatch on the very next transfer.

// File: rtl/cip_pkg.sv
package cip_pkg;

  localparam int PRE_LEN = 13;
  localparam int MRK_LEN = 8;

  typedef enum logic [3:0] {
    S_HDR, S_MRK, S_TYPE, S_LEN, S_SKIP, S_PAY, S_LEGK, S_LEG, S_DRAIN
  } cip_state_e;

  // Fixed container preamble, position i.
  function automatic logic [7:0] preamble_byte(input logic [3:0] i);
    if (i == 4'd0 || i == 4'd10 || i == 4'd11) return 8'h00;
    else if (i == 4'd1)  return 8'h09;
    else if (i == 4'd12) return 8'h01;
    else if (i[0])       return 8'hF0;
    else                 return 8'h0F;
  endfunction

  // Legacy marker as it arrives in the stream.
  function automatic logic [7:0] marker_in(input logic [2:0] i);
    case (i)
      3'd4:    return 8'h66;
      3'd5:    return 8'h55;
      3'd6:    return 8'h99;
      3'd7:    return 8'hAA;
      default: return 8'hFF;
    endcase
  endfunction

  // Legacy marker as it leaves, each 4-byte group reversed.
  function automatic logic [7:0] marker_out(input logic [2:0] i);
    return marker_in({i[2], ~i[1:0]});
  endfunction

  function automatic logic is_tag(input logic [7:0] d);
    return (d >= 8'h61) && (d <= 8'h65);
  endfunction

endpackage

// File: rtl/cip_rev.sv
module cip_rev #(
  parameter int GRP = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  input  logic       out_ready
);
  localparam int PW = (GRP > 1) ? $clog2(GRP) : 1;
  localparam logic [PW-1:0] LAST = PW'(GRP - 1);

  logic [7:0]    mem_q [GRP];
  logic [PW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic          full_q, full_n;
  logic          wr_en;

  assign in_ready  = !full_q;
  assign out_valid = full_q;
  assign out_data  = mem_q[rp_q];
  assign wr_en     = in_valid && !full_q && !clr;

  always_comb begin
    wp_n   = wp_q;
    rp_n   = rp_q;
    full_n = full_q;
    if (clr) begin
      wp_n   = '0;
      full_n = 1'b0;
    end else if (wr_en) begin
      if (wp_q == LAST) begin
        wp_n   = '0;
        rp_n   = LAST;
        full_n = 1'b1;
      end else begin
        wp_n = wp_q + 1'b1;
      end
    end else if (full_q && out_ready) begin
      if (rp_q == '0) full_n = 1'b0;
      else            rp_n   = rp_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      full_q <= 1'b0;
    end else begin
      wp_q   <= wp_n;
      rp_q   <= rp_n;
      full_q <= full_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < GRP; g++) mem_q[g] <= '0;
    end else if (wr_en) begin
      for (int g = 0; g < GRP; g++)
        if (wp_q == PW'(g)) mem_q[g] <= in_data;
    end
  end

  // R8: a held output byte stays put until taken
  a_r8_rev_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !clr) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/cip_fsm.sv
module cip_fsm
  import cip_pkg::*;
#(
  parameter int LEN_W     = 32,
  parameter int MAX_SHORT = 255,
  parameter int LEG_WORDS = 10524,
  parameter int GRP       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  output logic             out_valid,
  output logic [7:0]       out_data,
  input  logic             out_ready,
  output logic [LEN_W-1:0] pay_len,
  output logic             byte_rev,
  output logic             found,
  output logic             miss,
  output logic             err,
  output logic             rev_in_valid,
  input  logic             rev_in_ready,
  input  logic             rev_out_valid,
  input  logic [7:0]       rev_out_data,
  output logic             rev_out_ready,
  output logic             rev_clr
);
  localparam int LEG_BYTES = LEG_WORDS * GRP;
  localparam logic [LEN_W-1:0] LEG_TOT  = LEN_W'(LEG_BYTES);
  localparam logic [LEN_W-1:0] LEG_REST = LEN_W'(LEG_BYTES - MRK_LEN);
  localparam logic [LEN_W-1:0] SHORT_LIM = LEN_W'(MAX_SHORT);

  cip_state_e       state_q, state_n;
  logic [3:0]       idx_q, idx_n;
  logic [1:0]       lcnt_q, lcnt_n;
  logic             is_e_q, is_e_n;
  logic [LEN_W-1:0] len_q, len_n, cnt_q, cnt_n, icnt_q, icnt_n;
  logic [LEN_W-1:0] plen_q, plen_n, new_len;
  logic             last_q, last_n, rev_q, rev_n;
  logic             acc;

  assign new_len  = {len_q[LEN_W-9:0], in_data};
  assign pay_len  = plen_q;
  assign byte_rev = rev_q;

  always_comb begin
    state_n = state_q;  idx_n  = idx_q;  lcnt_n = lcnt_q; is_e_n = is_e_q;
    len_n   = len_q;    cnt_n  = cnt_q;  icnt_n = icnt_q; plen_n = plen_q;
    rev_n   = rev_q;
    found = 1'b0; miss = 1'b0; err = 1'b0;
    in_ready = 1'b0; out_valid = 1'b0; out_data = in_data;
    rev_in_valid = 1'b0; rev_out_ready = 1'b0; rev_clr = 1'b0;
    acc = 1'b0;
    case (state_q)
      S_HDR: begin
        in_ready = 1'b1;
        acc = in_valid;
        if (acc) begin
          rev_n = 1'b0;
          if (idx_q == 4'd0 && in_data == 8'hFF) begin
            if (in_last) miss = 1'b1;
            else begin state_n = S_MRK; idx_n = 4'd1; end
          end else if (in_data != preamble_byte(idx_q) || in_last) begin
            miss = 1'b1;
          end else if (idx_q == 4'(PRE_LEN - 1)) begin
            state_n = S_TYPE;
          end else begin
            idx_n = idx_q + 4'd1;
          end
        end
      end
      S_MRK: begin
        in_ready = 1'b1;
        acc = in_valid;
        if (acc) begin
          if (in_data != marker_in(idx_q[2:0])) miss = 1'b1;
          else if (idx_q == 4'(MRK_LEN - 1)) begin
            if (in_last) err = 1'b1;
            else begin
              state_n = S_LEGK; idx_n = 4'd0; rev_n = 1'b1; plen_n = LEG_TOT;
            end
          end else if (in_last) miss = 1'b1;
          else idx_n = idx_q + 4'd1;
        end
      end
      S_TYPE: begin
        in_ready = 1'b1;
        acc = in_valid;
        if (acc) begin
          if (!is_tag(in_data)) err = 1'b1;
          else if (in_last) miss = 1'b1;
          else begin
            state_n = S_LEN;
            is_e_n  = (in_data == 8'h65);
            lcnt_n  = (in_data == 8'h65) ? 2'd3 : 2'd1;
            len_n   = '0;
          end
        end
      end
      S_LEN: begin
        in_ready = 1'b1;
        acc = in_valid;
        if (acc) begin
          len_n = new_len;
          if (lcnt_q != 2'd0) begin
            if (in_last) miss = 1'b1;
            else lcnt_n = lcnt_q - 2'd1;
          end else if (is_e_q) begin
            plen_n = new_len;
            if (new_len == '0) found = 1'b1;
            else if (in_last) err = 1'b1;
            else begin state_n = S_PAY; cnt_n = new_len; end
          end else if (new_len > SHORT_LIM) begin
            err = 1'b1;
          end else if (in_last) begin
            miss = 1'b1;
          end else if (new_len == '0) begin
            state_n = S_TYPE;
          end else begin
            state_n = S_SKIP; cnt_n = new_len;
          end
        end
      end
      S_SKIP: begin
        in_ready = 1'b1;
        acc = in_valid;
        if (acc) begin
          if (in_last) miss = 1'b1;
          else if (cnt_q == LEN_W'(1)) state_n = S_TYPE;
          else cnt_n = cnt_q - LEN_W'(1);
        end
      end
      S_PAY: begin
        in_ready  = out_ready;
        out_valid = in_valid;
        acc = in_valid && out_ready;
        if (acc) begin
          if (cnt_q == LEN_W'(1)) found = 1'b1;
          else if (in_last) err = 1'b1;
          else cnt_n = cnt_q - LEN_W'(1);
        end
      end
      S_LEGK: begin
        out_valid = 1'b1;
        out_data  = marker_out(idx_q[2:0]);
        if (out_ready) begin
          if (idx_q == 4'(MRK_LEN - 1)) begin
            state_n = S_LEG; cnt_n = LEG_REST; icnt_n = LEG_REST;
          end else begin
            idx_n = idx_q + 4'd1;
          end
        end
      end
      S_LEG: begin
        rev_in_valid  = in_valid && (icnt_q != '0);
        in_ready      = rev_in_ready && (icnt_q != '0);
        acc           = in_valid && in_ready;
        out_valid     = rev_out_valid;
        out_data      = rev_out_data;
        rev_out_ready = out_ready;
        if (acc) begin
          icnt_n = icnt_q - LEN_W'(1);
          if (in_last && icnt_q != LEN_W'(1)) begin
            err = 1'b1; rev_clr = 1'b1;
          end
        end
        if (rev_out_valid && out_ready) begin
          if (cnt_q == LEN_W'(1)) found = 1'b1;
          else cnt_n = cnt_q - LEN_W'(1);
        end
      end
      default: begin
        in_ready = 1'b1;
        acc = in_valid;
        if (acc && in_last) state_n = S_HDR;
      end
    endcase
    if (found || miss || err) begin
      idx_n   = 4'd0;
      state_n = (last_q || (acc && in_last)) ? S_HDR : S_DRAIN;
    end
    last_n = (state_n == S_HDR) ? 1'b0 : (last_q || (acc && in_last));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_HDR; idx_q <= '0; lcnt_q <= '0; is_e_q <= 1'b0;
      len_q <= '0; cnt_q <= '0; icnt_q <= '0; plen_q <= '0;
      last_q <= 1'b0; rev_q <= 1'b0;
    end else begin
      state_q <= state_n; idx_q <= idx_n; lcnt_q <= lcnt_n; is_e_q <= is_e_n;
      len_q <= len_n; cnt_q <= cnt_n; icnt_q <= icnt_n; plen_q <= plen_n;
      last_q <= last_n; rev_q <= rev_n;
    end
  end

  // R11: status pulses never coincide
  a_r11_one_status: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({found, miss, err}));

  // R5: a skipped section never holds more than the short-length limit
  a_r5_skip_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_SKIP) |-> (cnt_q <= SHORT_LIM && cnt_q != '0));

  // R9: reversal mode is entered only from a matched legacy marker
  a_r9_rev_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_rev) |-> ($past(state_q) == S_MRK));

  // R7: success is reported only while a length or payload is in flight
  a_r7_found_src: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (state_q == S_PAY || state_q == S_LEG || state_q == S_LEN));

endmodule

// File: rtl/cfg_image_parser.sv
module cfg_image_parser #(
  parameter int LEN_W     = 32,
  parameter int MAX_SHORT = 255,
  parameter int LEG_WORDS = 10524,
  parameter int GRP       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  output logic             out_valid,
  output logic [7:0]       out_data,
  input  logic             out_ready,
  output logic [LEN_W-1:0] pay_len,
  output logic             byte_rev,
  output logic             found,
  output logic             miss,
  output logic             err
);
  logic       rv_in_valid, rv_in_ready, rv_out_valid, rv_out_ready, rv_clr;
  logic [7:0] rv_out_data;

  cip_fsm #(
    .LEN_W(LEN_W), .MAX_SHORT(MAX_SHORT), .LEG_WORDS(LEG_WORDS), .GRP(GRP)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .pay_len(pay_len), .byte_rev(byte_rev),
    .found(found), .miss(miss), .err(err),
    .rev_in_valid(rv_in_valid), .rev_in_ready(rv_in_ready),
    .rev_out_valid(rv_out_valid), .rev_out_data(rv_out_data),
    .rev_out_ready(rv_out_ready), .rev_clr(rv_clr)
  );

  cip_rev #(.GRP(GRP)) u_rev (
    .clk(clk), .rst_n(rst_n), .clr(rv_clr),
    .in_valid(rv_in_valid), .in_data(in_data), .in_ready(rv_in_ready),
    .out_valid(rv_out_valid), .out_data(rv_out_data), .out_ready(rv_out_ready)
  );

endmodule

// File: tb/cfg_image_parser_test.sv
module cfg_image_parser_test;
  localparam int CLK_PERIOD = 10;
  localparam int LEG_BYTES  = 10524 * 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic [7:0] in_data = 8'h00;
  logic in_ready, out_valid, byte_rev, found, miss, err;
  logic [7:0] out_data;
  logic [31:0] pay_len;

  int n_run = 0, n_fail = 0;
  int c_found = 0, c_miss = 0, c_err = 0, c_multi = 0;
  logic [7:0] expq [$];
  logic [7:0] img [$];
  string cur_tag = "R0";
  bit bp_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  cfg_image_parser uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready), .pay_len(pay_len),
    .byte_rev(byte_rev), .found(found), .miss(miss), .err(err)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Back-pressure generator, changes away from the active edge
  always begin
    @(posedge clk); #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = bp_en ? lfsr[0] : 1'b1;
  end

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          n_run++; n_fail++;
          $display("FAIL %s unexpected output byte: actual %0d expected none", cur_tag, out_data);
        end else begin
          logic [7:0] e;
          e = expq.pop_front();
          if (out_data !== e) begin
            n_run++; n_fail++;
            $display("FAIL %s payload byte: actual %0d expected %0d", cur_tag, out_data, e);
          end
        end
      end
      if (found) c_found++;
      if (miss)  c_miss++;
      if (err)   c_err++;
      if (int'(found) + int'(miss) + int'(err) > 1) c_multi++;
    end
  end

  function automatic logic [7:0] pre_b(input int i);
    if (i == 0 || i == 10 || i == 11) return 8'h00;
    if (i == 1) return 8'h09;
    if (i == 12) return 8'h01;
    return (i % 2 == 1) ? 8'hF0 : 8'h0F;
  endfunction

  function automatic logic [7:0] leg_in(input int i);
    logic [7:0] m [8] = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h66, 8'h55, 8'h99, 8'hAA};
    if (i < 8) return m[i];
    return 8'((i * 7 + 3) & 255);
  endfunction

  task automatic add_pre();
    for (int i = 0; i < 13; i++) img.push_back(pre_b(i));
  endtask

  // Section: tag, length, content seed; content of 'e' goes to the scoreboard
  task automatic add_sec(input logic [7:0] tag, input int len, input int nbytes, input int seed);
    img.push_back(tag);
    if (tag == 8'h65) begin
      img.push_back(8'(len >> 24)); img.push_back(8'(len >> 16));
    end
    img.push_back(8'(len >> 8)); img.push_back(8'(len));
    for (int k = 0; k < nbytes; k++) begin
      img.push_back(8'(seed + k * 3));
      if (tag == 8'h65) expq.push_back(8'(seed + k * 3));
    end
  endtask

  task automatic send_img();
    for (int i = 0; i < img.size(); i++) begin
      in_valid = 1'b1;
      in_data  = img[i];
      in_last  = (i == img.size() - 1);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    img.delete();
    repeat (20) @(posedge clk);
    #1;
  endtask

  task automatic run_chk(input string tag, input int ef, input int em, input int ee);
    int f0, m0, e0;
    f0 = c_found; m0 = c_miss; e0 = c_err;
    cur_tag = tag;
    send_img();
    chk(c_found - f0 == ef, tag, "found pulses", c_found - f0, ef);
    chk(c_miss - m0 == em, tag, "miss pulses", c_miss - m0, em);
    chk(c_err - e0 == ee, tag, "err pulses", c_err - e0, ee);
    chk(expq.size() == 0, tag, "payload bytes left undelivered", expq.size(), 0);
    expq.delete();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL R0 watchdog expired: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    chk(in_ready == 1'b1, "R1", "reset in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R3", "reset out_valid", out_valid, 0);
    chk({found, miss, err} == 3'b000, "R11", "reset status", {found, miss, err}, 0);
    chk(byte_rev == 1'b0 && pay_len == 0, "R9", "reset rev/len", pay_len, 0);
    @(posedge clk); #1;

    // R2 R3 R7 R11: skipped sections, payload, trailing look-alike bytes
    add_pre();
    add_sec(8'h61, 3, 3, 8'h10);
    add_sec(8'h62, 0, 0, 0);
    add_sec(8'h65, 5, 5, 8'h40);
    for (int i = 0; i < 6; i++) img.push_back(pre_b(i));
    run_chk("R3", 1, 0, 0);
    chk(pay_len == 5, "R3", "pay_len", pay_len, 5);
    chk(byte_rev == 1'b0, "R3", "byte_rev", byte_rev, 0);

    // R8 R5 boundary: 255-byte skip, payload under random back-pressure
    bp_en = 1'b1;
    add_pre();
    add_sec(8'h63, 255, 255, 8'h01);
    add_sec(8'h64, 2, 2, 8'h77);
    add_sec(8'h65, 40, 40, 8'h90);
    run_chk("R8", 1, 0, 0);
    chk(pay_len == 40, "R8", "pay_len", pay_len, 40);
    bp_en = 1'b0;

    // R4: illegal tag
    add_pre(); add_sec(8'h61, 2, 2, 8'h05);
    img.push_back(8'h66); img.push_back(8'h00); img.push_back(8'h65);
    run_chk("R4", 0, 0, 1);

    // R5: short-length section over the limit
    add_pre(); img.push_back(8'h64); img.push_back(8'h01); img.push_back(8'h00);
    img.push_back(8'h33);
    run_chk("R5", 0, 0, 1);

    // R6: image ends after a skipped section
    add_pre(); add_sec(8'h61, 4, 4, 8'h20);
    run_chk("R6", 0, 1, 0);

    // R1: preamble byte 5 wrong
    for (int i = 0; i < 13; i++) img.push_back(i == 5 ? 8'hF1 : pre_b(i));
    img.push_back(8'h65);
    run_chk("R1", 0, 1, 0);

    // R7 R11: empty payload, image right after earlier trailing bytes
    add_pre(); add_sec(8'h65, 0, 0, 0); img.push_back(8'h12);
    run_chk("R7", 1, 0, 0);
    chk(pay_len == 0, "R11", "pay_len after restart", pay_len, 0);

    // R12: truncated payload
    add_pre(); add_sec(8'h65, 10, 4, 8'hC0);
    run_chk("R12", 0, 0, 1);

    // R10: legacy marker mismatch in its last byte
    for (int i = 0; i < 7; i++) img.push_back(leg_in(i));
    img.push_back(8'hAB); img.push_back(8'h00);
    run_chk("R10", 0, 1, 0);
    chk(byte_rev == 1'b0, "R10", "byte_rev", byte_rev, 0);

    // R9: full legacy raw image, reversed per 4-byte group
    for (int k = 0; k < LEG_BYTES; k++) begin
      img.push_back(leg_in(k));
      expq.push_back(leg_in((k & ~3) | (3 - (k & 3))));
    end
    run_chk("R9", 1, 0, 0);
    chk(byte_rev == 1'b1, "R9", "byte_rev", byte_rev, 1);
    chk(pay_len == LEG_BYTES, "R9", "pay_len", pay_len, LEG_BYTES);

    chk(c_multi == 0, "R11", "cycles with several status pulses", c_multi, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule